// File: doc/BRIEF.md
# Execute Stage Function Unit

This block is the arithmetic and logic stage of a small load/store processor core. In one issue it takes two 32-bit register operands, a 16-bit immediate, a 5-bit shift count and a 4-bit function code. It returns one result word and four status flags: negative, zero, overflow and carry.

Inside, the block has a constant unit that widens the immediate by either zero-filling it or sign-extending it. A single control bit picks which. The widened constant can stand in for the second register operand. The block also has a logarithmic barrel shifter that moves the first operand by any count from 0 to 31 in one pass. The result selector has a dedicated input for the signed set-if-less-than value. That value is taken from the sign and overflow of a subtraction.

A single output register holds the result and flags. They are therefore available one clock after the operands are accepted. Results can be issued back to back on every cycle.

Top module: `exu_top`

## Requirements
- R1: While reset (active-low `rstN`) is held, and right after it, `outValid`, `result` and all four flags read 0.
- R2: An issue with `inValid`=1 at a rising edge produces `outValid`=1 with its result and flags after that same edge, and stays visible until the next edge. A cycle with `inValid`=0 gives `outValid`=0 after the edge. Issues on consecutive cycles each give exactly one result, in order.
- R3: With `useImm`=1 and `constSign`=0, the second operand is `{16'h0, immIn}`.
- R4: With `useImm`=1 and `constSign`=1, the second operand is `immIn` sign-extended from bit 15.
- R5: Code 1 gives A+B and code 2 gives A-B. C is the carry out; for subtract this is 1 when there is no borrow (A >= B unsigned). V is set on two's-complement overflow.
- R6: Code 0 passes A, code 3 is AND, code 4 is OR, code 5 is XOR, code 6 is the bitwise NOT of A, and code 11 passes B.
- R7: Code 7 shifts A left, code 8 shifts it right logically, and code 9 shifts it right arithmetically, each by `shAmt` places (0 to 31). A count of 0 returns A unchanged.
- R8: Code 10 gives a result of 1 when A < B as signed numbers, taken as N xor V of A-B, and 0 otherwise. Bits 31:1 are always 0. V and C report that subtraction.
- R9: Z is 1 exactly when the result word is zero, and N equals result bit 31.
- R10: For every code other than 1, 2 and 10, C and V are 0.
- R11: Codes 12 to 15 give a zero result, with Z=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operands and function code are valid this cycle |
| funcSel | input | 4 | Function code (see R5 to R11) |
| opA | input | 32 | First register operand |
| opB | input | 32 | Second register operand |
| immIn | input | 16 | Immediate field |
| useImm | input | 1 | 1: the widened constant replaces `opB` |
| constSign | input | 1 | 0: zero-fill the immediate, 1: sign-extend it |
| shAmt | input | 5 | Shift count |
| outValid | output | 1 | Result and flags are valid |
| result | output | 32 | Result word |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag |

## Verification
All results are due one rising edge after their issue edge, with no extra latency for shifts, immediates or set-less-than. The driver applies each operation at a falling edge and queues its expected word and flags. The monitor samples at the next falling edge, where `outValid` must already be high, and compares against the head of the queue. Back-to-back issues check that no result is lost, duplicated or reordered. Idle cycles are used to confirm that `outValid` drops on the first edge without an issue.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [2:0] {
    ALU_PASSA,
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR,
    ALU_NOTA,
    ALU_PASSB
  } aluOp_e;

  typedef enum logic [1:0] {
    RES_ALU,
    RES_SHIFT,
    RES_SLT,
    RES_ZERO
  } resSel_e;

  typedef struct packed {
    aluOp_e  aluOp;
    resSel_e resSel;
    logic    shLeft;
    logic    shArith;
    logic    arithFlags;
    logic    useImm;
    logic    constSign;
  } exuStrobe_t;

endpackage

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
(
  input  logic [3:0]  funcSel,
  input  logic        useImm,
  input  logic        constSign,
  output exuStrobe_t  strobe
);

  always_comb begin
    strobe            = '0;
    strobe.aluOp      = ALU_PASSA;
    strobe.resSel     = RES_ALU;
    strobe.useImm     = useImm;
    strobe.constSign  = constSign;
    unique case (funcSel)
      4'd0:  strobe.aluOp = ALU_PASSA;
      4'd1:  begin strobe.aluOp = ALU_ADD; strobe.arithFlags = 1'b1; end
      4'd2:  begin strobe.aluOp = ALU_SUB; strobe.arithFlags = 1'b1; end
      4'd3:  strobe.aluOp = ALU_AND;
      4'd4:  strobe.aluOp = ALU_OR;
      4'd5:  strobe.aluOp = ALU_XOR;
      4'd6:  strobe.aluOp = ALU_NOTA;
      4'd7:  begin strobe.resSel = RES_SHIFT; strobe.shLeft = 1'b1; end
      4'd8:  strobe.resSel = RES_SHIFT;
      4'd9:  begin strobe.resSel = RES_SHIFT; strobe.shArith = 1'b1; end
      4'd10: begin
        strobe.aluOp      = ALU_SUB;
        strobe.resSel     = RES_SLT;
        strobe.arithFlags = 1'b1;
      end
      4'd11: strobe.aluOp = ALU_PASSB;
      default: strobe.resSel = RES_ZERO;
    endcase
  end

endmodule

// File: rtl/exu_barrel.sv
module exu_barrel #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  logic              shLeft,
  input  logic              shArith,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stage [0:SH_W];
  logic              fillBit;

  assign fillBit  = shArith & din[DATA_W-1];
  assign stage[0] = din;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    logic [DATA_W-1:0] moved;
    always_comb begin
      if (shLeft) begin
        moved = stage[i] << STEP;
      end else begin
        moved = (stage[i] >> STEP) |
                (fillBit ? ~({DATA_W{1'b1}} >> STEP) : '0);
      end
    end
    assign stage[i+1] = amt[i] ? moved : stage[i];
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/exu_dp.sv
module exu_dp
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  exuStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immIn,
  input  logic [SH_W-1:0]   shAmt,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);

  localparam int MSB   = DATA_W - 1;
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] constExt;
  logic [DATA_W-1:0] opBSel;
  logic [DATA_W-1:0] addendB;
  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sum;
  logic              carryOut;
  logic              overflow;
  logic              subMode;
  logic              sltBit;
  logic [DATA_W-1:0] aluRes;
  logic [DATA_W-1:0] shOut;
  logic [DATA_W-1:0] resNext;
  resSel_e           resSelQ;
  logic              arithQ;

  // constant unit
  assign constExt = strobe.constSign ? {{EXT_W{immIn[IMM_W-1]}}, immIn}
                                     : {{EXT_W{1'b0}}, immIn};
  assign opBSel   = strobe.useImm ? constExt : opB;

  // adder shared by add, subtract and set-less-than
  assign subMode  = (strobe.aluOp == ALU_SUB);
  assign addendB  = subMode ? ~opBSel : opBSel;
  assign sumWide  = {1'b0, opA} + {1'b0, addendB} + {{DATA_W{1'b0}}, subMode};
  assign sum      = sumWide[DATA_W-1:0];
  assign carryOut = sumWide[DATA_W];
  assign overflow = (opA[MSB] == addendB[MSB]) && (sum[MSB] != opA[MSB]);
  assign sltBit   = sum[MSB] ^ overflow;

  always_comb begin
    unique case (strobe.aluOp)
      ALU_PASSA: aluRes = opA;
      ALU_ADD,
      ALU_SUB:   aluRes = sum;
      ALU_AND:   aluRes = opA & opBSel;
      ALU_OR:    aluRes = opA | opBSel;
      ALU_XOR:   aluRes = opA ^ opBSel;
      ALU_NOTA:  aluRes = ~opA;
      ALU_PASSB: aluRes = opBSel;
      default:   aluRes = '0;
    endcase
  end

  exu_barrel #(
    .DATA_W (DATA_W),
    .SH_W   (SH_W)
  ) u_barrel (
    .din     (opA),
    .amt     (shAmt),
    .shLeft  (strobe.shLeft),
    .shArith (strobe.shArith),
    .dout    (shOut)
  );

  // result multiplexer
  always_comb begin
    unique case (strobe.resSel)
      RES_ALU:   resNext = aluRes;
      RES_SHIFT: resNext = shOut;
      RES_SLT:   resNext = {{(DATA_W-1){1'b0}}, sltBit};
      default:   resNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      flagN    <= 1'b0;
      flagZ    <= 1'b0;
      flagV    <= 1'b0;
      flagC    <= 1'b0;
      resSelQ  <= RES_ZERO;
      arithQ   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result  <= resNext;
        flagN   <= resNext[MSB];
        flagZ   <= (resNext == '0);
        flagV   <= strobe.arithFlags & overflow;
        flagC   <= strobe.arithFlags & carryOut;
        resSelQ <= strobe.resSel;
        arithQ  <= strobe.arithFlags;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R2
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.useImm && !strobe.constSign) |-> (opBSel == {{EXT_W{1'b0}}, immIn})); // R3
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.useImm && strobe.constSign) |-> (opBSel[MSB:IMM_W] == {EXT_W{immIn[IMM_W-1]}})); // R4
  AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && shAmt == '0) |-> (shOut == opA)); // R7
  AST_SLT_ZEXT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && resSelQ == RES_SLT) |-> (result[MSB:1] == '0)); // R8
  AST_NO_CV_LOGIC: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !arithQ) |-> (!flagC && !flagV)); // R10

endmodule

// File: rtl/exu_top.sv
module exu_top
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        funcSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  immIn,
  input  logic              useImm,
  input  logic              constSign,
  input  logic [SH_W-1:0]   shAmt,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagV,
  output logic              flagC
);

  exuStrobe_t strobe;

  exu_ctrl u_ctrl (
    .funcSel   (funcSel),
    .useImm    (useImm),
    .constSign (constSign),
    .strobe    (strobe)
  );

  exu_dp #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .SH_W   (SH_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .immIn    (immIn),
    .shAmt    (shAmt),
    .outValid (outValid),
    .result   (result),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagV    (flagV),
    .flagC    (flagC)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!outValid && result == '0)); // R1
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagZ == (result == '0))); // R9

endmodule

// File: tb/sim_exu_top.sv
`timescale 1ns/1ps
module sim_exu_top;

  typedef struct {
    logic [31:0] res;
    logic        n, z, v, c;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  funcSel = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [15:0] immIn = '0;
  logic        useImm = 1'b0, constSign = 1'b0;
  logic [4:0]  shAmt = '0;
  logic        outValid, flagN, flagZ, flagV, flagC;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  exu_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .funcSel(funcSel),
    .opA(opA), .opB(opB), .immIn(immIn), .useImm(useImm),
    .constSign(constSign), .shAmt(shAmt), .outValid(outValid),
    .result(result), .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  function automatic expItem_t model(input logic [3:0] f, input logic [31:0] a,
      input logic [31:0] b, input logic [15:0] imm, input logic ui,
      input logic cs, input logic [4:0] sh, input string tag);
    expItem_t e;
    logic [31:0] bb;
    logic [32:0] w;
    logic        ov, ar;
    bb = ui ? (cs ? {{16{imm[15]}}, imm} : {16'h0, imm}) : b;
    w = '0; ov = 1'b0; ar = 1'b0;
    e.res = '0;
    case (f)
      4'd0: e.res = a;
      4'd1: begin
        w = {1'b0, a} + {1'b0, bb}; ar = 1'b1;
        ov = (a[31] == bb[31]) && (w[31] != a[31]); e.res = w[31:0];
      end
      4'd2, 4'd10: begin
        w = {1'b0, a} + {1'b0, ~bb} + 33'd1; ar = 1'b1;
        ov = (a[31] != bb[31]) && (w[31] != a[31]);
        e.res = (f == 4'd2) ? w[31:0] : {31'd0, ($signed(a) < $signed(bb))};
      end
      4'd3: e.res = a & bb;
      4'd4: e.res = a | bb;
      4'd5: e.res = a ^ bb;
      4'd6: e.res = ~a;
      4'd7: e.res = a << sh;
      4'd8: e.res = a >> sh;
      4'd9: e.res = $unsigned($signed(a) >>> sh);
      4'd11: e.res = bb;
      default: e.res = '0;
    endcase
    e.n = e.res[31];
    e.z = (e.res == '0);
    e.v = ar & ov;
    e.c = ar & w[32];
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
      input logic [15:0] imm, input logic ui, input logic cs, input logic [4:0] sh,
      input string tag);
    @(negedge clk);
    inValid = 1'b1; funcSel = f; opA = a; opB = b; immIn = imm;
    useImm = ui; constSign = cs; shAmt = sh;
    expQ.push_back(model(f, a, b, imm, ui, cs, sh, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; funcSel = '0; opA = '0; opB = '0;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
      input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pop and compare each result as it appears
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected outValid", 64'd1, 64'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check({result, flagN, flagZ, flagV, flagC} == {e.res, e.n, e.z, e.v, e.c},
              e.tag, "result/NZVC",
              {28'd0, result, flagN, flagZ, flagV, flagC},
              {28'd0, e.res, e.n, e.z, e.v, e.c});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check({outValid, result, flagN, flagZ, flagV, flagC} == '0, "R1", "reset outputs",
          {27'd0, outValid, result, flagN, flagZ, flagV, flagC}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid after reset", {63'd0, outValid}, 64'd0);

    // R5 add and subtract
    send(4'd1, 32'd5, 32'd7, 16'h0, 0, 0, 0, "R5 add");
    send(4'd1, 32'h7fffffff, 32'd1, 16'h0, 0, 0, 0, "R5 add overflow");
    send(4'd1, 32'hffffffff, 32'd1, 16'h0, 0, 0, 0, "R9 add carry zero");
    send(4'd2, 32'd3, 32'd5, 16'h0, 0, 0, 0, "R5 sub borrow");
    send(4'd2, 32'd5, 32'd5, 16'h0, 0, 0, 0, "R9 sub zero");
    send(4'd2, 32'h80000000, 32'd1, 16'h0, 0, 0, 0, "R5 sub overflow");
    // R3, R4 constant unit
    send(4'd1, 32'd0, 32'hdeadbeef, 16'h8001, 1, 0, 0, "R3 zero fill");
    send(4'd1, 32'd0, 32'hdeadbeef, 16'h8001, 1, 1, 0, "R4 sign extend");
    send(4'd11, 32'd0, 32'h0, 16'h7fff, 1, 1, 0, "R4 positive imm");
    // R6 and R10 logic
    send(4'd3, 32'hf0f0ff00, 32'h0ff0f0f0, 16'h0, 0, 0, 0, "R6 and");
    send(4'd4, 32'hf0f00000, 32'h0000000f, 16'h0, 0, 0, 0, "R6 or");
    send(4'd5, 32'hffff0000, 32'hff00ff00, 16'h0, 0, 0, 0, "R6 xor");
    send(4'd6, 32'h0000ffff, 32'h0, 16'h0, 0, 0, 0, "R10 not");
    send(4'd0, 32'h80000001, 32'h0, 16'h0, 0, 0, 0, "R6 pass a");
    // R7 shifts
    send(4'd7, 32'h12345678, 32'h0, 16'h0, 0, 0, 5'd0, "R7 shl by 0");
    send(4'd7, 32'h00000001, 32'h0, 16'h0, 0, 0, 5'd31, "R7 shl by 31");
    send(4'd8, 32'h80000000, 32'h0, 16'h0, 0, 0, 5'd4, "R7 shr by 4");
    send(4'd9, 32'h80000000, 32'h0, 16'h0, 0, 0, 5'd31, "R7 sra by 31");
    send(4'd9, 32'h40000000, 32'h0, 16'h0, 0, 0, 5'd3, "R7 sra positive");
    send(4'd8, 32'hcafef00d, 32'h0, 16'h0, 0, 0, 5'd0, "R7 shr by 0");
    idle();
    idle();
    check(outValid == 1'b0, "R2", "outValid drops when idle", {63'd0, outValid}, 64'd0);
    // R8 set less than
    send(4'd10, 32'hffffffff, 32'd1, 16'h0, 0, 0, 0, "R8 -1<1");
    send(4'd10, 32'd1, 32'hffffffff, 16'h0, 0, 0, 0, "R8 1<-1");
    send(4'd10, 32'h80000000, 32'd1, 16'h0, 0, 0, 0, "R8 overflow true");
    send(4'd10, 32'h7fffffff, 32'h80000000, 16'h0, 0, 0, 0, "R8 overflow false");
    send(4'd10, 32'd2, 32'd0, 16'hfffe, 1, 1, 0, "R8 imm -2");
    // R11 reserved codes
    send(4'd12, 32'h11111111, 32'h2, 16'h0, 0, 0, 0, "R11 code 12");
    send(4'd15, 32'hffffffff, 32'hff, 16'h0, 0, 0, 0, "R11 code 15");
    idle();
    idle();
    check(expQ.size() == 0, "R2", "all results delivered",
          {32'd0, expQ.size()}, 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule